// File: doc/BRIEF.md
# Memory Barrier Ordering Tracker

This block sits beside the dispatch stage of an out-of-order core and records which memory barriers are still in flight. It answers one question each cycle: when a load or a store is dispatched, which older instruction must it wait for? If an ordering barrier covering that kind of access is outstanding, the answer is the barrier's sequence number. Otherwise the answer is the producer sequence number that the dependence predictor supplied alongside the query. The answer zero means the instruction has no memory dependence and may issue once its operands are ready.

Two barrier kinds exist. A full barrier orders both later loads and later stores. A write-only barrier orders only later stores. The block keeps one flag and one tag for loads and one flag and one tag for stores. A flag drops only when a completion or a squash names the exact instruction recorded in its tag, so a newer barrier is never released by an older one retiring. Sequence numbers are `SEQ_W` bits, zero is reserved, and they are assumed not to wrap within the in-flight window. A squash discards every instruction younger than its sequence number.

Top module: `mem_barrier_tracker`

## Requirements
- R1: After reset, or in the cycle after `takeover` is high, both barrier flags are clear and both tags are zero, so every query returns the predictor value.
- R2: A full barrier insert (`ins_valid` with `ins_full`=1) makes both load queries and store queries return its sequence number from the next cycle on.
- R3: A write-only barrier insert (`ins_valid` with `ins_full`=0) makes store queries return its sequence number from the next cycle; load queries keep the answer they had.
- R4: While no barrier covers the query type, `dep_seq` equals `q_pred_seq` (zero stays zero, meaning no dependence); with `q_valid` low `dep_seq` is zero. The answer is combinational from the state held before the current edge.
- R5: A full barrier completion (`cmp_valid`, `cmp_full`=1) clears the load flag only if the load tag equals `cmp_seq`, and the store flag only if the store tag equals `cmp_seq`.
- R6: A write-only barrier completion (`cmp_valid`, `cmp_full`=0) can clear only the store flag, and only when the store tag equals `cmp_seq`; the load flag is untouched.
- R7: A squash (`sq_valid`) clears every flag whose tag is greater than `sq_seq`; flags whose tag is less than or equal to `sq_seq` survive.
- R8: When an insert arrives in the same cycle as a completion or squash, the insert wins for each flag it writes; flags it does not write follow R5 to R7.
- R9: A newer barrier insert replaces the tag of an older one, so completing the older barrier afterwards does not release the newer one.
- R10: `takeover` overrides any insert, completion or squash in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| takeover | input | 1 | Synchronous clear of all barrier state |
| ins_valid | input | 1 | Barrier insert event |
| ins_full | input | 1 | 1: full barrier, 0: write-only barrier |
| ins_seq | input | SEQ_W | Sequence number of the inserted barrier (nonzero) |
| cmp_valid | input | 1 | Barrier completion event |
| cmp_full | input | 1 | 1: completing barrier is full, 0: write-only |
| cmp_seq | input | SEQ_W | Sequence number of the completing barrier |
| sq_valid | input | 1 | Squash event |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| q_valid | input | 1 | Dispatch query present |
| q_is_store | input | 1 | 1: query is for a store, 0: for a load |
| q_pred_seq | input | SEQ_W | Producer from the dependence predictor (0 = none) |
| dep_seq | output | SEQ_W | Producer the dispatched instruction waits on (0 = none) |

## Verification
Directed sequences separate the two barrier kinds: a full barrier must redirect load and store queries alike, while a write-only barrier must leave load answers untouched, and completions with matching and mismatching tags show that only the named instruction releases a flag. Squash points above and below a barrier's tag tell a younger barrier from an older survivor. Same-cycle insert with completion, and takeover with insert, pin down the priorities. A long random stream with sequence numbers drawn from a small range forces frequent tag collisions, so tag equality and ordering decide the outcome often, and each cycle's answer is compared for both query types against a model built from the requirements.

// File: rtl/mem_barrier_tracker.sv
module mem_barrier_tracker #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             takeover,
  input  logic             ins_valid,
  input  logic             ins_full,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic             cmp_valid,
  input  logic             cmp_full,
  input  logic [SEQ_W-1:0] cmp_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic             q_valid,
  input  logic             q_is_store,
  input  logic [SEQ_W-1:0] q_pred_seq,
  output logic [SEQ_W-1:0] dep_seq
);

  logic             ld_flag, st_flag;
  logic [SEQ_W-1:0] ld_tag, st_tag;

  wire ld_set  = ins_valid && ins_full;
  wire st_set  = ins_valid;
  wire ld_drop = (cmp_valid && cmp_full && (ld_tag == cmp_seq)) ||
                 (sq_valid && (ld_tag > sq_seq));
  wire st_drop = (cmp_valid && (st_tag == cmp_seq)) ||
                 (sq_valid && (st_tag > sq_seq));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_flag <= 1'b0;
      ld_tag  <= '0;
    end else if (takeover) begin
      ld_flag <= 1'b0;
      ld_tag  <= '0;
    end else if (ld_set) begin
      ld_flag <= 1'b1;
      ld_tag  <= ins_seq;
    end else if (ld_drop) begin
      ld_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_flag <= 1'b0;
      st_tag  <= '0;
    end else if (takeover) begin
      st_flag <= 1'b0;
      st_tag  <= '0;
    end else if (st_set) begin
      st_flag <= 1'b1;
      st_tag  <= ins_seq;
    end else if (st_drop) begin
      st_flag <= 1'b0;
    end
  end

  wire             use_tag = q_is_store ? st_flag : ld_flag;
  wire [SEQ_W-1:0] tag_sel = q_is_store ? st_tag  : ld_tag;

  assign dep_seq = !q_valid ? '0 : (use_tag ? tag_sel : q_pred_seq);

endmodule

// File: rtl/mem_barrier_tracker_chk.sv
module mem_barrier_tracker_chk #(
  parameter int SEQ_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             takeover,
  input logic             ins_valid,
  input logic             ins_full,
  input logic [SEQ_W-1:0] ins_seq,
  input logic             cmp_valid,
  input logic             cmp_full,
  input logic [SEQ_W-1:0] cmp_seq,
  input logic             sq_valid,
  input logic [SEQ_W-1:0] sq_seq,
  input logic             q_valid,
  input logic             q_is_store,
  input logic [SEQ_W-1:0] q_pred_seq,
  input logic [SEQ_W-1:0] dep_seq,
  input logic             ld_flag,
  input logic             st_flag,
  input logic [SEQ_W-1:0] ld_tag,
  input logic [SEQ_W-1:0] st_tag
);

  assert_clear_after_takeover_R1: assert property (@(posedge clk) disable iff (!rst_n)
    takeover |=> (!ld_flag && !st_flag && ld_tag == '0 && st_tag == '0));

  assert_full_sets_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_full && !takeover) |=> (ld_flag && ld_tag == $past(ins_seq)));

  assert_insert_seq_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |-> ins_seq != '0);

  assert_write_keeps_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_full && !takeover && !cmp_valid && !sq_valid)
      |=> (ld_flag == $past(ld_flag) && ld_tag == $past(ld_tag)));

  assert_pred_passthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_is_store && !ld_flag) |-> dep_seq == q_pred_seq);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> dep_seq == '0);

  assert_mismatch_keeps_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !takeover && !ins_valid && !sq_valid && ld_tag != cmp_seq)
      |=> ld_flag == $past(ld_flag));

  assert_write_cmp_spares_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_full && !takeover && !ins_valid && !sq_valid)
      |=> ld_flag == $past(ld_flag));

  assert_squash_younger_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !takeover && !ins_valid && st_tag > sq_seq) |=> !st_flag);

  assert_insert_beats_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && (cmp_valid || sq_valid) && !takeover) |=> st_flag);

endmodule

bind mem_barrier_tracker mem_barrier_tracker_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .takeover(takeover),
  .ins_valid(ins_valid), .ins_full(ins_full), .ins_seq(ins_seq),
  .cmp_valid(cmp_valid), .cmp_full(cmp_full), .cmp_seq(cmp_seq),
  .sq_valid(sq_valid), .sq_seq(sq_seq),
  .q_valid(q_valid), .q_is_store(q_is_store), .q_pred_seq(q_pred_seq),
  .dep_seq(dep_seq),
  .ld_flag(ld_flag), .st_flag(st_flag), .ld_tag(ld_tag), .st_tag(st_tag)
);

// File: tb/tb_mem_barrier_tracker.sv
module tb_mem_barrier_tracker;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic takeover = 1'b0;
  logic ins_valid = 1'b0, ins_full = 1'b0;
  logic [W-1:0] ins_seq = '0;
  logic cmp_valid = 1'b0, cmp_full = 1'b0;
  logic [W-1:0] cmp_seq = '0;
  logic sq_valid = 1'b0;
  logic [W-1:0] sq_seq = '0;
  logic q_valid = 1'b0, q_is_store = 1'b0;
  logic [W-1:0] q_pred_seq = '0;
  logic [W-1:0] dep_seq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic m_ld, m_st;
  logic [W-1:0] m_ld_tag, m_st_tag;

  always #4 clk = ~clk;

  mem_barrier_tracker #(.SEQ_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .takeover(takeover),
    .ins_valid(ins_valid), .ins_full(ins_full), .ins_seq(ins_seq),
    .cmp_valid(cmp_valid), .cmp_full(cmp_full), .cmp_seq(cmp_seq),
    .sq_valid(sq_valid), .sq_seq(sq_seq),
    .q_valid(q_valid), .q_is_store(q_is_store), .q_pred_seq(q_pred_seq),
    .dep_seq(dep_seq)
  );

  function automatic logic [W-1:0] expect_dep(input logic qv, input logic qs,
                                              input logic [W-1:0] pred);
    if (!qv) return '0;
    if (qs) return m_st ? m_st_tag : pred;
    return m_ld ? m_ld_tag : pred;
  endfunction

  task automatic check(input logic [W-1:0] got, input logic [W-1:0] exp,
                       input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: dep_seq got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic model_update();
    logic nld, nst;
    logic [W-1:0] nlt, nstg;
    nld = m_ld; nst = m_st; nlt = m_ld_tag; nstg = m_st_tag;
    if (takeover) begin
      nld = 0; nst = 0; nlt = '0; nstg = '0;
    end else begin
      if (ins_valid && ins_full) begin nld = 1; nlt = ins_seq; end
      else if ((cmp_valid && cmp_full && m_ld_tag == cmp_seq) ||
               (sq_valid && m_ld_tag > sq_seq)) nld = 0;
      if (ins_valid) begin nst = 1; nstg = ins_seq; end
      else if ((cmp_valid && m_st_tag == cmp_seq) ||
               (sq_valid && m_st_tag > sq_seq)) nst = 0;
    end
    m_ld = nld; m_st = nst; m_ld_tag = nlt; m_st_tag = nstg;
  endtask

  // Drive one cycle of events, check both query types against the model,
  // then advance the model across the clock edge.
  task automatic step(input logic tk,
                      input logic iv, input logic ifl, input logic [W-1:0] is,
                      input logic cv, input logic cfl, input logic [W-1:0] cs,
                      input logic sv, input logic [W-1:0] ss,
                      input logic [W-1:0] pred, input string tag);
    takeover = tk;
    ins_valid = iv; ins_full = ifl; ins_seq = is;
    cmp_valid = cv; cmp_full = cfl; cmp_seq = cs;
    sq_valid = sv; sq_seq = ss;
    q_valid = 1'b1; q_is_store = 1'b0; q_pred_seq = pred;
    #1 check(dep_seq, expect_dep(1'b1, 1'b0, pred), {tag, " load"});
    q_is_store = 1'b1;
    #1 check(dep_seq, expect_dep(1'b1, 1'b1, pred), {tag, " store"});
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic idle(input logic [W-1:0] pred, input string tag);
    step(0, 0,0,'0, 0,0,'0, 0,'0, pred, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ld = 0; m_st = 0; m_ld_tag = '0; m_st_tag = '0;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R4: reset state, predictor pass-through including zero
    idle(16'd7, "R1 reset");
    idle(16'd0, "R4 zero pred");
    q_valid = 1'b0; q_pred_seq = 16'd9;
    #1 check(dep_seq, 16'd0, "R4 no query");
    @(negedge clk);

    // R2: full barrier 10
    step(0, 1,1,16'd10, 0,0,'0, 0,'0, 16'd3, "R2 insert");
    idle(16'd3, "R2 full covers both");
    // R3 / R9: write barrier 20 replaces store tag, load stays 10
    step(0, 1,0,16'd20, 0,0,'0, 0,'0, 16'd3, "R3 insert");
    idle(16'd3, "R3 write covers store only");
    // R5: completing full 10 clears load, store tag 20 mismatches
    step(0, 0,0,'0, 1,1,16'd10, 0,'0, 16'd4, "R5 cmp");
    idle(16'd4, "R5 tag match rule");
    // R9: older completion of 10 again leaves store held by 20
    step(0, 0,0,'0, 1,1,16'd10, 0,'0, 16'd4, "R9 stale cmp");
    idle(16'd4, "R9 newer survives");
    // R6: write completion 20 clears store
    step(0, 0,0,'0, 1,0,16'd20, 0,'0, 16'd5, "R6 cmp");
    idle(16'd5, "R6 store cleared");
    // R6: full 30 then write completion 30 leaves load held
    step(0, 1,1,16'd30, 0,0,'0, 0,'0, 16'd5, "R6 setup");
    step(0, 0,0,'0, 1,0,16'd30, 0,'0, 16'd5, "R6 write cmp");
    idle(16'd5, "R6 load untouched");
    // R7: squash below tag clears, above tag survives
    step(0, 1,1,16'd40, 0,0,'0, 0,'0, 16'd6, "R7 setup");
    step(0, 0,0,'0, 0,0,'0, 1,16'd35, 16'd6, "R7 squash younger");
    idle(16'd6, "R7 cleared");
    step(0, 1,1,16'd50, 0,0,'0, 0,'0, 16'd6, "R7 setup2");
    step(0, 0,0,'0, 0,0,'0, 1,16'd60, 16'd6, "R7 squash older");
    idle(16'd6, "R7 survives");
    step(0, 0,0,'0, 0,0,'0, 1,16'd50, 16'd6, "R7 squash equal");
    idle(16'd6, "R7 equal survives");
    // R8: write insert 70 with full completion 50 in one cycle
    step(0, 1,0,16'd70, 1,1,16'd50, 0,'0, 16'd8, "R8 collide");
    idle(16'd8, "R8 insert wins store, load released");
    step(0, 1,1,16'd80, 0,0,'0, 1,16'd1, 16'd8, "R8 insert vs squash");
    idle(16'd8, "R8 insert beats squash");
    // R10: takeover with simultaneous insert
    step(1, 1,1,16'd90, 0,0,'0, 0,'0, 16'd2, "R10 takeover");
    idle(16'd2, "R10 cleared");

    // Random traffic with a narrow sequence range to force tag collisions
    for (int i = 0; i < 4000; i++) begin
      logic tk, iv, ifl, cv, cfl, sv;
      logic [W-1:0] is, cs, ss, pr;
      tk  = ($urandom % 64) == 0;
      iv  = ($urandom % 4) == 0;
      ifl = $urandom % 2;
      is  = W'(1 + ($urandom % 12));
      cv  = ($urandom % 3) == 0;
      cfl = $urandom % 2;
      cs  = W'(1 + ($urandom % 12));
      sv  = ($urandom % 6) == 0;
      ss  = W'($urandom % 13);
      pr  = W'($urandom % 4);
      step(tk, iv,ifl,is, cv,cfl,cs, sv,ss, pr, "R4/R5/R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule